// File: doc/BRIEF.md
# Timer master trigger output selector

This block is a small up-counting timer that can drive a synchronisation pulse or level to other timers. A counter of parameterised width counts up while it is enabled. When it reaches the reload value it returns to zero, and at that wrap it raises a one-cycle update pulse. The counter can also be forced back to zero. Software does this by writing a self-clearing restart bit. An external trigger can do it when trigger-reset mode is on.

The trigger output is registered. A 3-bit source selector picks what drives it:
- the restart pulse,
- the effective counter enable, or
- the update event.

The effective enable is the run bit ORed with the synchronised trigger input when gated mode is on. Because the trigger output is registered, it lags the trigger input by one clock. An alignment bit delays every effect of the trigger input inside this timer by one clock, so that this timer and the timers it drives act on the same edge.

Software configures the block through a simple write-only port with four word addresses. The external trigger passes through a two-flop synchroniser before the block uses it.

Top module: `tmo_timer`

## Requirements
- R1: After reset, count, update and trig_out are 0, every control field is 0, and the counter holds at 0 until it is enabled.
- R2: When the run bit (address 0, bit 0) is 1, count rises by one per clock. The first increment happens at the clock edge after the one that stores the bit.
- R3: When count equals the reload value (address 3, reset value all ones) and the counter is enabled, the next edge sets count to 0 and raises update for exactly one cycle.
- R4: Writing 1 to address 0 bit 1 sets count to 0 and pulses update for one cycle at the write edge. This bit is never stored, and it takes priority over a wrap that falls in the same cycle.
- R5: The source selector is address 1 bits 2:0. With code 000, trig_out is high for one cycle, coincident with the update pulse from a software restart.
- R6: With code 001, trig_out equals the effective enable (run OR (gate AND synchronised trigger)), delayed by one clock.
- R7: With code 010, trig_out equals update in every cycle.
- R8: With codes 011 through 111, trig_out stays 0.
- R9: trig_in passes through two synchroniser flops. In gated mode (address 2, bit 0), count first increments, and trig_out (code 001) first rises, on the third edge after trig_in rises.
- R10: In trigger-reset mode (address 2, bit 1), a rising synchronised trigger sets count to 0 and pulses update. With code 000, trig_out pulses one cycle after that reset.
- R11: With the alignment bit (address 1, bit 3) set, every effect of the trigger input on the counter comes one clock later. In gated mode the count then first increments on the fourth edge, while trig_out still rises on the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 8 | Register write data |
| trig_in | input | 1 | Asynchronous trigger input |
| trig_out | output | 1 | Registered synchronisation output |
| count | output | 8 | Counter value |
| update | output | 1 | One-cycle update event |

## Verification
A software restart and a counter wrap can fall in the same cycle. To provoke this, the bench writes the restart bit exactly while count sits at the reload value. It then checks three things: count lands on zero, update pulses once instead of twice, and the following cycle shows count 1 with update low. A second collision is between a register write that changes the trigger-output source and an event in flight. The assertions judge this by comparing trig_out against the source selected on the previous edge.

// File: rtl/tmo_pkg.sv
package tmo_pkg;

    typedef logic [2:0] msel_t;

    localparam msel_t MS_RESET  = 3'b000;
    localparam msel_t MS_ENABLE = 3'b001;
    localparam msel_t MS_UPDATE = 3'b010;

    typedef struct packed {
        logic  cen;
        msel_t msel;
        logic  msm;
        logic  gate;
        logic  trst;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '0;

endpackage

// File: rtl/tmo_sync.sv
module tmo_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic sync_o,
    output logic dly1_o,
    output logic dly2_o
);
    localparam int N = STAGES + 2;

    logic [N-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[N-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
    assign dly1_o = chain_q[STAGES];
    assign dly2_o = chain_q[STAGES+1];

    // R9: each delay tap is the previous one shifted by a clock
    a_r9_chain: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (dly1_o == $past(sync_o)));

endmodule

// File: rtl/tmo_counter.sv
module tmo_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cnt_en,
    input  logic          clr,
    input  logic [CW-1:0] reload,
    output logic [CW-1:0] cnt,
    output logic          upd_evt,
    output logic          upd
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          upd;
    } st_t;

    localparam logic [CW-1:0] ONE = {{(CW-1){1'b0}}, 1'b1};

    st_t  st_d, st_q;
    logic wrap;

    always_comb begin
        st_d    = st_q;
        wrap    = cnt_en && !clr && (st_q.cnt == reload);
        upd_evt = clr || wrap;
        if (clr || wrap) st_d.cnt = '0;
        else if (cnt_en) st_d.cnt = st_q.cnt + ONE;
        st_d.upd = upd_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
    assign upd = st_q.upd;

    a_r2_increment: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !clr && cnt != reload) |=> (cnt == $past(cnt) + ONE) && !upd);

    a_r3_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_en && !clr && cnt == reload) |=> (cnt == '0) && upd);

    a_r4_clear: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0) && upd);

    a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_en && !clr) |=> $stable(cnt) && !upd);

endmodule

// File: rtl/tmo_trgo_sel.sv
module tmo_trgo_sel
    import tmo_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  msel_t msel,
    input  logic  ug,
    input  logic  trst_evt,
    input  logic  en_raw,
    input  logic  upd_evt,
    output logic  trgo
);
    typedef struct packed {
        logic pend;
        logic trgo;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d.pend = trst_evt;
        case (msel)
            MS_RESET:  st_d.trgo = ug || st_q.pend;
            MS_ENABLE: st_d.trgo = en_raw;
            MS_UPDATE: st_d.trgo = upd_evt;
            default:   st_d.trgo = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trgo = st_q.trgo;

    a_r8_reserved_low: assert property (@(posedge clk) disable iff (!rst_n)
        (msel > MS_UPDATE) |=> !trgo);

    a_r10_late_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (msel == MS_RESET && trst_evt) |=> ##1 ($past(msel) != MS_RESET || trgo));

endmodule

// File: rtl/tmo_timer.sv
module tmo_timer
    import tmo_pkg::*;
#(
    parameter int CW     = 8,
    parameter int AW     = 2,
    parameter int STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [CW-1:0] wr_data,
    input  logic          trig_in,
    output logic          trig_out,
    output logic [CW-1:0] count,
    output logic          update
);
    localparam logic [AW-1:0] A_CTRL   = AW'(0);
    localparam logic [AW-1:0] A_MASTER = AW'(1);
    localparam logic [AW-1:0] A_SLAVE  = AW'(2);
    localparam logic [AW-1:0] A_RELOAD = AW'(3);

    typedef struct packed {
        ctrl_t         ctl;
        logic [CW-1:0] reload;
    } regs_t;

    regs_t regs_d, regs_q;

    logic ug, trig_s, trig_d1, trig_d2;
    logic trig_eff, trig_eff_prev, rise, trst_evt, clr;
    logic en_raw, cnt_en, upd_evt;

    tmo_sync #(.STAGES(STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(trig_in),
        .sync_o(trig_s), .dly1_o(trig_d1), .dly2_o(trig_d2)
    );

    always_comb begin
        regs_d = regs_q;
        ug     = wr_en && (wr_addr == A_CTRL) && wr_data[1];
        if (wr_en) begin
            case (wr_addr)
                A_CTRL:   regs_d.ctl.cen = wr_data[0];
                A_MASTER: begin
                    regs_d.ctl.msel = wr_data[2:0];
                    regs_d.ctl.msm  = wr_data[3];
                end
                A_SLAVE: begin
                    regs_d.ctl.gate = wr_data[0];
                    regs_d.ctl.trst = wr_data[1];
                end
                default:  regs_d.reload = wr_data;
            endcase
        end

        trig_eff      = regs_q.ctl.msm ? trig_d1 : trig_s;
        trig_eff_prev = regs_q.ctl.msm ? trig_d2 : trig_d1;
        rise          = trig_eff && !trig_eff_prev;
        trst_evt      = regs_q.ctl.trst && rise;
        clr           = ug || trst_evt;
        en_raw        = regs_q.ctl.cen || (regs_q.ctl.gate && trig_s);
        cnt_en        = regs_q.ctl.cen || (regs_q.ctl.gate && trig_eff);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.ctl    <= CTRL_RST;
            regs_q.reload <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    tmo_counter #(.CW(CW)) u_counter (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .clr(clr),
        .reload(regs_q.reload), .cnt(count), .upd_evt(upd_evt), .upd(update)
    );

    tmo_trgo_sel u_trgo (
        .clk(clk), .rst_n(rst_n), .msel(regs_q.ctl.msel), .ug(ug),
        .trst_evt(trst_evt), .en_raw(en_raw), .upd_evt(upd_evt), .trgo(trig_out)
    );

    a_r7_update_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctl.msel == MS_UPDATE) |=> (trig_out == update));

    a_r6_enable_mode: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctl.msel == MS_ENABLE && regs_q.ctl.cen) |=> trig_out);

    a_r5_sw_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctl.msel == MS_RESET && ug) |=> (trig_out && update && count == '0));

    a_r11_aligned_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.ctl.msm && regs_q.ctl.gate && !regs_q.ctl.cen && !trig_d1 && !clr)
            |=> $stable(count));

endmodule

// File: tb/tmo_timer_test.sv
`timescale 1ns/1ps
module tmo_timer_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       trig_in = 1'b0;
    logic       trig_out;
    logic [7:0] count;
    logic       update;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    tmo_timer uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .trig_in(trig_in), .trig_out(trig_out),
        .count(count), .update(update)
    );

    // per selector code: {code, trig_out at restart edge, trig_out one cycle later}
    localparam logic [7:0][4:0] VEC = {
        {3'd7, 1'b0, 1'b0}, {3'd6, 1'b0, 1'b0}, {3'd5, 1'b0, 1'b0},
        {3'd4, 1'b0, 1'b0}, {3'd3, 1'b0, 1'b0}, {3'd2, 1'b1, 1'b0},
        {3'd1, 1'b1, 1'b1}, {3'd0, 1'b1, 1'b0}
    };

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        chk("R1 count", count, 8'd0);
        chk("R1 update", {7'd0, update}, 8'd0);
        chk("R1 trig_out", {7'd0, trig_out}, 8'd0);
        step(2);
        chk("R1 idle count", count, 8'd0);

        // R2: run bit
        wr(2'd0, 8'h01);
        chk("R2 first edge", count, 8'd0);
        step(2);
        chk("R2 counting", count, 8'd2);

        // vector table over every selector code (R4 R5 R6 R7 R8)
        for (int i = 0; i < 8; i++) begin
            wr(2'd1, {5'd0, VEC[i][4:2]});
            wr(2'd0, 8'h03);
            chk($sformatf("R4 clear code%0d", i), count, 8'd0);
            chk($sformatf("R4 update code%0d", i), {7'd0, update}, 8'd1);
            chk($sformatf("R5_R6_R7_R8 edge code%0d", i), {7'd0, trig_out}, {7'd0, VEC[i][1]});
            step(1);
            chk($sformatf("R5_R6_R7_R8 next code%0d", i), {7'd0, trig_out}, {7'd0, VEC[i][0]});
            chk($sformatf("R4 single pulse code%0d", i), {7'd0, update}, 8'd0);
            chk($sformatf("R2 resume code%0d", i), count, 8'd1);
        end

        // R3 wrap with update-source output (R7)
        wr(2'd1, 8'h02);
        wr(2'd3, 8'h03);
        wr(2'd0, 8'h03);
        chk("R3 start", count, 8'd0);
        step(3);
        chk("R3 at reload", count, 8'd3);
        chk("R3 no early pulse", {7'd0, update}, 8'd0);
        step(1);
        chk("R3 wrapped", count, 8'd0);
        chk("R3 wrap pulse", {7'd0, update}, 8'd1);
        chk("R7 follows wrap", {7'd0, trig_out}, 8'd1);
        step(3);
        chk("R4 collision setup", count, 8'd3);
        wr(2'd0, 8'h03);
        chk("R4 collision clear", count, 8'd0);
        chk("R4 collision pulse", {7'd0, update}, 8'd1);
        step(1);
        chk("R4 collision single", {7'd0, update}, 8'd0);
        chk("R4 collision count", count, 8'd1);

        // R9 / R6 gated mode through synchroniser
        wr(2'd0, 8'h00);
        wr(2'd3, 8'hFF);
        wr(2'd2, 8'h01);
        wr(2'd1, 8'h01);
        wr(2'd0, 8'h02);
        chk("R9 gated base", count, 8'd0);
        trig_in = 1'b1;
        step(2);
        chk("R9 sync hold count", count, 8'd0);
        chk("R9 sync hold trig_out", {7'd0, trig_out}, 8'd0);
        step(1);
        chk("R9 third edge count", count, 8'd1);
        chk("R6 gated trig_out", {7'd0, trig_out}, 8'd1);
        trig_in = 1'b0;
        step(2);
        chk("R9 falling count", count, 8'd3);
        chk("R6 falling trig_out", {7'd0, trig_out}, 8'd1);
        step(1);
        chk("R9 gate closed count", count, 8'd3);
        chk("R6 gate closed trig_out", {7'd0, trig_out}, 8'd0);

        // R11 alignment delay
        wr(2'd1, 8'h09);
        trig_in = 1'b1;
        step(3);
        chk("R11 trig_out on time", {7'd0, trig_out}, 8'd1);
        chk("R11 count delayed", count, 8'd3);
        step(1);
        chk("R11 count fourth edge", count, 8'd4);
        trig_in = 1'b0;
        step(6);

        // R10 trigger reset with late trig_out
        wr(2'd2, 8'h02);
        wr(2'd1, 8'h00);
        wr(2'd0, 8'h01);
        step(4);
        trig_in = 1'b1;
        step(2);
        chk("R10 before reset trig_out", {7'd0, trig_out}, 8'd0);
        step(1);
        chk("R10 reset count", count, 8'd0);
        chk("R10 reset update", {7'd0, update}, 8'd1);
        chk("R10 trig_out not yet", {7'd0, trig_out}, 8'd0);
        step(1);
        chk("R10 late trig_out", {7'd0, trig_out}, 8'd1);
        chk("R10 count resumes", count, 8'd1);

        finish_run();
    end

endmodule